// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave (SMBus-style byte and block protocol). It gives an external host read and write access to a small bank of 8-bit configuration registers. The whole bank is also presented on a parallel output bus, so that neighbouring logic can consume the settings directly.

The first byte after a start condition holds a 7-bit device address and a direction bit. On a write, the next byte is a command. Its top bit chooses between a one-register access and a block access. Its low bits name the register to access, or the first register of a block. A block write carries a byte count ahead of the data. A block read answers with a byte count ahead of the data. The clock and data lines are oversampled on the system clock. The slave pulls SDA low through an output enable. While the power-down input is high, the block holds its reset state and does not answer the bus.

Top module: `smbus_cfg_slave`

## Requirements
- R1: After reset, register i holds i*0x11, with bit 7 forced to 1 when i is odd, and `sda_oe` is 0.
- R2: Bits 7:1 of the first byte after a start are the address and bit 0 is the direction (0 = write, 1 = read). When the address equals `DEV_ADDR`, the slave acknowledges by driving `sda_oe` = 1 during the ninth clock.
- R3: A command byte with bit 7 = 1 selects a one-register access at the offset in bits 6:0. In a write, the first data byte is acknowledged and stored, and any further data byte gets no acknowledge and is not stored.
- R4: Bit 7 of every odd-numbered register is reserved. It always reads 1, and writes to it have no effect.
- R5: A command byte with bit 7 = 0 selects a block access. In a block write, the byte after the command is a count N, and the following N data bytes go to consecutive registers starting at the offset. Register indices wrap from NUM_REGS-1 to 0.
- R6: In a block write, data bytes beyond the count N get no acknowledge and change no register.
- R7: When the address does not match, the slave gives no acknowledge and ignores every following byte until the next start.
- R8: A one-register read is: write address, command, repeated start, then the address with the read bit. The slave sends the register at the command offset, most significant bit first.
- R9: A block read is the same sequence with a block command. The slave first sends the count byte NUM_REGS, then sends registers from the offset onward, wrapping, for as long as the master acknowledges. After the master's not-acknowledge the slave releases SDA.
- R10: While `pwr_dn` is 1, every register returns to its R1 value and the slave acknowledges nothing.
- R11: Command offset bits above log2(NUM_REGS) are ignored, so the register index is the offset modulo NUM_REGS.
- R12: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; holds the block in reset and off the bus |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_regs_o | output | NUM_REGS*8 | Register bank, register i at bits 8i+7:8i |

## Verification
The bench uses the default build: NUM_REGS = 8 and DEV_ADDR = 0x52. A bank of eight registers lets a four-byte block write starting at offset 6 cross the wrap from register 7 to register 0. With the same bank, a command offset of 0x0C lands on register 4, which shows that the upper offset bits are dropped. The eight-register size also makes every odd register carry a reserved bit, and the count byte of a block read is known in advance.

// File: rtl/smbrs_pkg.sv
package smbrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WCNT, ST_WDAT, ST_RCNT, ST_RDAT, ST_IGN
  } smb_state_e;

  // reset contents of register idx (reserved ones merged in by the bank)
  function automatic logic [7:0] reg_default(int idx);
    return 8'(idx * 17);
  endfunction

  // reserved-bit mask of register idx: bit 7 of odd registers
  function automatic logic [7:0] reg_rsvd(int idx);
    return (idx % 2 == 1) ? 8'h80 : 8'h00;
  endfunction

endpackage

// File: rtl/smbrs_sync.sv
module smbrs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sn,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic sda_fall
);

  logic [1:0] rst_q;
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
    end
  end

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_q[1] & ~scl_p;
  assign scl_fall = ~scl_q[1] & scl_p;
  assign sda_rise = sda_q[1] & ~sda_p;
  assign sda_fall = ~sda_q[1] & sda_p;

endmodule

// File: rtl/smbrs_regfile.sv
module smbrs_regfile #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] regs_o
);
  import smbrs_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RSVD  = reg_rsvd(g);
    localparam logic [7:0] RSTV  = reg_default(g) | RSVD;
    logic [7:0] q;
    logic       hit;

    assign hit = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RSTV;
      else if (clr) q <= RSTV;
      else if (hit) q <= (wdata & ~RSVD) | RSVD;
    end

    assign regs_o[g*8 +: 8] = q;

    // R4: reserved bits never read as 0
    a_r4_rsvd_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (q & RSVD) == RSVD);
  end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter int             NUM_REGS = 8,
  parameter logic [6:0]     DEV_ADDR = 7'h52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_dn,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs_o
);
  import smbrs_pkg::*;

  localparam int          IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0]  CNT_BYTE = 8'(NUM_REGS);

  logic rst_sn, scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;

  smbrs_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_sn(rst_sn), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall)
  );

  smb_state_e       st_q, st_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sreg_q, sreg_d;
  logic [7:0]       txb_q, txb_d;
  logic [7:0]       rem_q, rem_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             blk_q, blk_d;
  logic             rd_q, rd_d;
  logic             nack_q, nack_d;
  logic             oe_q, oe_d;
  logic             reg_we;
  logic [7:0]       rd_byte;
  logic             start_det, stop_det, is_tx;

  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;
  assign is_tx     = (st_q == ST_RCNT) || (st_q == ST_RDAT);
  assign rd_byte   = cfg_regs_o[{ptr_q, 3'b000} +: 8];

  smbrs_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .clr(pwr_dn), .we(reg_we),
    .widx(ptr_q), .wdata(sreg_q), .regs_o(cfg_regs_o)
  );

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sreg_d = sreg_q;
    txb_d  = txb_q;
    rem_d  = rem_q;
    ptr_d  = ptr_q;
    blk_d  = blk_q;
    rd_d   = rd_q;
    nack_d = nack_q;
    oe_d   = oe_q;
    reg_we = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      bit_d = 4'd0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (st_q != ST_IDLE && st_q != ST_IGN) begin
      if (scl_rise) begin
        if (bit_q < 4'd8)  sreg_d = {sreg_q[6:0], sda_s};
        if (bit_q == 4'd8) nack_d = sda_s;
        bit_d = bit_q + 4'd1;
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          if (is_tx) begin
            oe_d = 1'b0;
          end else begin
            unique case (st_q)
              ST_ADDR: begin
                if (sreg_q[7:1] == DEV_ADDR) begin
                  oe_d = 1'b1;
                  rd_d = sreg_q[0];
                end else begin
                  st_d = ST_IGN;
                end
              end
              ST_CMD: begin
                oe_d  = 1'b1;
                blk_d = ~sreg_q[7];
                ptr_d = sreg_q[IDX_W-1:0];
                rem_d = 8'd1;
              end
              ST_WCNT: begin
                oe_d  = 1'b1;
                rem_d = sreg_q;
              end
              ST_WDAT: begin
                if (rem_q != 8'd0) begin
                  oe_d   = 1'b1;
                  reg_we = 1'b1;
                  ptr_d  = ptr_q + 1'b1;
                  rem_d  = rem_q - 8'd1;
                end else begin
                  st_d = ST_IGN;
                end
              end
              default: ;
            endcase
          end
        end else if (bit_q == 4'd9) begin
          oe_d  = 1'b0;
          bit_d = 4'd0;
          unique case (st_q)
            ST_ADDR: begin
              if (!rd_q) begin
                st_d = ST_CMD;
              end else if (blk_q) begin
                st_d  = ST_RCNT;
                txb_d = CNT_BYTE;
                oe_d  = ~CNT_BYTE[7];
              end else begin
                st_d  = ST_RDAT;
                txb_d = rd_byte;
                ptr_d = ptr_q + 1'b1;
                oe_d  = ~rd_byte[7];
              end
            end
            ST_CMD:  st_d = blk_q ? ST_WCNT : ST_WDAT;
            ST_WCNT: st_d = ST_WDAT;
            ST_RCNT, ST_RDAT: begin
              if (nack_q) begin
                st_d = ST_IGN;
              end else begin
                st_d  = ST_RDAT;
                txb_d = rd_byte;
                ptr_d = ptr_q + 1'b1;
                oe_d  = ~rd_byte[7];
              end
            end
            default: ;
          endcase
        end else if (is_tx && bit_q != 4'd0) begin
          oe_d = ~txb_q[3'd7 - bit_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      bit_q  <= 4'd0;
      sreg_q <= 8'h00;
      txb_q  <= 8'h00;
      rem_q  <= 8'h00;
      ptr_q  <= '0;
      blk_q  <= 1'b0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (pwr_dn) begin
      st_q   <= ST_IDLE;
      bit_q  <= 4'd0;
      sreg_q <= 8'h00;
      txb_q  <= 8'h00;
      rem_q  <= 8'h00;
      ptr_q  <= '0;
      blk_q  <= 1'b0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sreg_q <= sreg_d;
      txb_q  <= txb_d;
      rem_q  <= rem_d;
      ptr_q  <= ptr_d;
      blk_q  <= blk_d;
      rd_q   <= rd_d;
      nack_q <= nack_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R12: data line changes only in the SCL low phase
  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_sn || pwr_dn)
    (!$stable(oe_q) && !$past(pwr_dn)) |-> !scl_s);

  // R7: an ignored transaction never drives the line
  a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IGN) |-> !oe_q);

  // R10: power-down leaves the slave idle and released
  a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    pwr_dn |=> (st_q == ST_IDLE && !oe_q));

  // R6: no register write once the byte allowance is used up
  a_r6_write_within_count: assert property (@(posedge clk) disable iff (!rst_sn || pwr_dn)
    reg_we |-> (rem_q != 8'd0 && st_q == ST_WDAT));

endmodule

// File: tb/smbus_cfg_slave_bench.sv
`timescale 1ns/1ps
module smbus_cfg_slave_bench;
  localparam int         NR  = 8;
  localparam logic [6:0] ADR = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  logic sda_line;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smbus_cfg_slave #(.NUM_REGS(NR), .DEV_ADDR(ADR)) u_smbus_cfg_slave (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs_o(regs)
  );

  function automatic logic [7:0] dflt(int i);
    return 8'(i * 17) | ((i % 2 == 1) ? 8'h80 : 8'h00);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] rg(int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic bus_start();
    tick(4); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(4); sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    tick(4); sda_m = b; tick(4); scl_m = 1'b1; tick(4);
    s = sda_line; tick(4); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(nack, s);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NR; i++) chk("R1 default", rg(i), dflt(i));
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_single_write();
    logic a;
    bus_start();
    send_byte({ADR, 1'b0}, a); chk("R2 address ack", a, 1);
    send_byte(8'h82, a);       chk("R3 command ack", a, 1);
    send_byte(8'h5A, a);       chk("R3 data ack", a, 1);
    send_byte(8'h33, a);       chk("R3 extra byte nack", a, 0);
    bus_stop();
    chk("R3 reg2 written", rg(2), 8'h5A);
    chk("R3 reg3 untouched", rg(3), dflt(3));
  endtask

  task automatic t_reserved();
    logic a;
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h83, a);
    send_byte(8'h00, a); bus_stop();
    chk("R4 reg3 bit7 kept", rg(3), 8'h80);
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h85, a);
    send_byte(8'h7F, a); bus_stop();
    chk("R4 reg5", rg(5), 8'hFF);
  endtask

  task automatic t_block_write();
    logic a;
    bus_start();
    send_byte({ADR, 1'b0}, a);
    send_byte(8'h06, a); chk("R5 block cmd ack", a, 1);
    send_byte(8'd4, a);  chk("R5 count ack", a, 1);
    for (int i = 1; i <= 4; i++) send_byte(8'(i), a);
    chk("R5 last data ack", a, 1);
    send_byte(8'hEE, a); chk("R6 beyond count nack", a, 0);
    bus_stop();
    chk("R5 reg6", rg(6), 8'h01);
    chk("R5 reg7", rg(7), 8'h82);
    chk("R5 wrap reg0", rg(0), 8'h03);
    chk("R5 wrap reg1", rg(1), 8'h84);
    chk("R6 reg2 untouched", rg(2), 8'h5A);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte({ADR ^ 7'h01, 1'b0}, a); chk("R7 no ack", a, 0);
    send_byte(8'h84, a); chk("R7 command ignored", a, 0);
    send_byte(8'h11, a); chk("R7 data ignored", a, 0);
    bus_stop();
    chk("R7 reg4 untouched", rg(4), dflt(4));
  endtask

  task automatic t_upper_offset();
    logic a;
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h8C, a);
    send_byte(8'hC3, a); bus_stop();
    chk("R11 offset 0x0C hits reg4", rg(4), 8'hC3);
  endtask

  task automatic t_single_read();
    logic a; logic [7:0] b;
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h82, a);
    bus_start();
    send_byte({ADR, 1'b1}, a); chk("R8 read address ack", a, 1);
    recv_byte(1'b1, b); chk("R8 read reg2", b, 8'h5A);
    bus_stop();
  endtask

  task automatic t_block_read();
    logic a; logic [7:0] b;
    bus_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h06, a);
    bus_start(); send_byte({ADR, 1'b1}, a);
    recv_byte(1'b0, b); chk("R9 count byte", b, NR);
    recv_byte(1'b0, b); chk("R9 reg6", b, 8'h01);
    recv_byte(1'b0, b); chk("R9 reg7", b, 8'h82);
    recv_byte(1'b1, b); chk("R9 wrap reg0", b, 8'h03);
    tick(6); chk("R9 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_pwrdn();
    logic a;
    pwr_dn = 1'b1; tick(3);
    chk("R10 reg2 default", rg(2), dflt(2));
    chk("R10 reg4 default", rg(4), dflt(4));
    bus_start(); send_byte({ADR, 1'b0}, a); chk("R10 no ack", a, 0);
    bus_stop();
    pwr_dn = 1'b0; tick(4);
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_single_write();
    t_reserved();
    t_block_write();
    t_bad_addr();
    t_upper_offset();
    t_single_read();
    t_block_read();
    t_pwrdn();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule